// File: doc/BRIEF.md
# Key-locked GPIO pad mode controller

This block is a memory-mapped controller for a bank of up to 32 general-purpose pins. For every pin it keeps an output data bit and two mode bits. The two mode bits choose how the pad is driven. The four choices are: input only, full push-pull drive, open-drain style pull-low, and open-source style pull-high. Software changes the output data through write-one-to-set and write-one-to-clear registers. The mode bits can be written whole, or changed bit by bit through dedicated set and clear registers.

The mode bits are protected by a separate lock register with its own write port. Mode writes take effect only while the lock is open. The lock opens when the 16-bit key 0xD42F is written to it, and any other key value closes it. This keeps a stray bus write from turning an input pad into a driver. Pad inputs are brought into the clock domain through a two-flop synchronizer and can be read back at any time.

Top module: `gpio_keyed_pads`

## Requirements
- R1: After reset every mode bit and every output data bit is 0 and the lock is closed. So pad_oe and pad_out are all 0, lock_rdata reads 0, and the mode registers read 0.
- R2: A lock write with lock_wdata[15:0] = 0xD42F opens the lock from the next cycle. A lock write with any other value in bits 15:0 (0x0000 included) closes it. lock_rdata bit 31 shows the lock state, and its other bits read 0. Without a lock write the state holds.
- R3: Writes to the mode registers (offsets 0x08, 0x0C, 0x50, 0x54, 0x58) change mode bits only when the lock was already open before that cycle's clock edge. Otherwise they are dropped. This holds even when a lock write comes in the same cycle.
- R4: A write to offset 0x08 replaces the whole mode1 word, and a write to offset 0x0C replaces the whole mode0 word. Both words read back at the same offsets.
- R5: Offset 0x54 sets, and offset 0x58 clears, the mode0 bits whose write-data bit is 1. Offset 0x50 clears those mode1 bits. Bits written as 0 are unchanged.
- R6: Offset 0x14 sets, and offset 0x18 clears, the output data bits whose write-data bit is 1. Bits written as 0 are unchanged. These writes do not depend on the lock.
- R7: Per pin, with {mode1,mode0} and data d, the pad drive is: 00 gives oe=0; 01 gives oe=1 and out=d; 10 gives oe=1 and out=0 when d=0, and oe=0 when d=1; 11 gives oe=0 when d=0, and oe=1 and out=1 when d=1. pad_out is 0 wherever pad_oe is 0.
- R8: A read of offset 0x04 returns pad_in as sampled two clock edges earlier, whatever the pin modes are.
- R9: Register bits at positions NPINS and above read as 0.
- R10: Reads of unmapped offsets return 0. Writes to them change no mode or data bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Register write strobe |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr (combinational) |
| lock_we | input | 1 | Lock register write strobe |
| lock_wdata | input | 32 | Lock write data, key in bits 15:0 |
| lock_rdata | output | 32 | Lock state in bit 31 |
| pad_in | input | NPINS | Pad input levels |
| pad_out | output | NPINS | Pad output levels |
| pad_oe | output | NPINS | Pad output enables |

## Verification
The hardest case to reach is a key write and a mode write that arrive in the same cycle. A correct design must drop that mode write, and it must accept the same write one cycle later. The bench drives both strobes on one clock edge, then repeats the mode write alone, and reads mode0 after each. A second hard case comes from mode1 having a clear register but no set register. Open-drain and open-source styles can therefore be reached only by a full load of mode1. The table-driven loop programs all four drive styles that way, against both data values.

// File: rtl/gpio_kp_pkg.sv
package gpio_kp_pkg;

  localparam int unsigned BUS_W  = 32;
  localparam int unsigned KEY_W  = 16;
  localparam logic [KEY_W-1:0] UNLOCK_KEY = 16'hD42F;

  localparam logic [7:0] OFS_DIN    = 8'h04;
  localparam logic [7:0] OFS_MODE1  = 8'h08;
  localparam logic [7:0] OFS_MODE0  = 8'h0C;
  localparam logic [7:0] OFS_DSET   = 8'h14;
  localparam logic [7:0] OFS_DCLR   = 8'h18;
  localparam logic [7:0] OFS_M1CLR  = 8'h50;
  localparam logic [7:0] OFS_M0SET  = 8'h54;
  localparam logic [7:0] OFS_M0CLR  = 8'h58;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_SET  = 2'd2,
    OP_CLR  = 2'd3
  } bit_op_e;

  // Next value of a bit vector under one bus operation.
  function automatic logic [BUS_W-1:0] apply_op(input logic [BUS_W-1:0] cur,
                                                input logic [BUS_W-1:0] wd,
                                                input bit_op_e op);
    case (op)
      OP_LOAD: apply_op = wd;
      OP_SET:  apply_op = cur | wd;
      OP_CLR:  apply_op = cur & ~wd;
      default: apply_op = cur;
    endcase
  endfunction

  // Output enable of one pad from its mode pair and data bit.
  function automatic logic drive_en(input logic m1, input logic m0, input logic d);
    case ({m1, m0})
      2'b01:   drive_en = 1'b1;
      2'b10:   drive_en = ~d;
      2'b11:   drive_en = d;
      default: drive_en = 1'b0;
    endcase
  endfunction

  // True when a lock write carries the unlock key.
  function automatic logic key_match(input logic [KEY_W-1:0] k);
    key_match = (k == UNLOCK_KEY);
  endfunction

endpackage

// File: rtl/gpio_kp_lock.sv
module gpio_kp_lock
  import gpio_kp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [KEY_W-1:0] key,
  output logic             active
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
    end else if (we) begin
      active <= key_match(key);
    end
  end

endmodule

// File: rtl/gpio_kp_bitreg.sv
module gpio_kp_bitreg
  import gpio_kp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  bit_op_e      op,
  input  logic [W-1:0] wd,
  output logic [W-1:0] q
);

  logic [BUS_W-1:0] nxt_wide;

  always_comb begin
    nxt_wide = apply_op(BUS_W'(q), BUS_W'(wd), op);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (op != OP_NONE) begin
      q <= nxt_wide[W-1:0];
    end
  end

endmodule

// File: rtl/gpio_kp_sync.sv
module gpio_kp_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] st [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st[g] <= '0;
        end else begin
          st[g] <= (g == 0) ? d : st[(g == 0) ? 0 : g - 1];
        end
      end
    end
  endgenerate

  assign q = st[STAGES-1];

endmodule

// File: rtl/gpio_kp_pad.sv
module gpio_kp_pad
  import gpio_kp_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] mode1,
  input  logic [W-1:0] mode0,
  input  logic [W-1:0] data,
  output logic [W-1:0] oe,
  output logic [W-1:0] out
);

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_pin
      assign oe[i]  = drive_en(mode1[i], mode0[i], data[i]);
      assign out[i] = oe[i] & data[i];
    end
  endgenerate

endmodule

// File: rtl/gpio_keyed_pads.sv
module gpio_keyed_pads
  import gpio_kp_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              lock_we,
  input  logic [31:0]       lock_wdata,
  output logic [31:0]       lock_rdata,
  input  logic [NPINS-1:0]  pad_in,
  output logic [NPINS-1:0]  pad_out,
  output logic [NPINS-1:0]  pad_oe
);

  localparam int unsigned SYNC_STAGES = 2;

  // Named internal events
  logic             lock_active;
  bit_op_e          mode0_req, mode1_req;
  bit_op_e          mode0_op, mode1_op, data_op;
  logic [NPINS-1:0] wd_pins;
  logic [NPINS-1:0] mode0_q, mode1_q, data_q, din_q;
  logic             unused_lock_hi;

  assign wd_pins        = bus_wdata[NPINS-1:0];
  assign unused_lock_hi = ^lock_wdata[31:KEY_W];

  // Write decode
  always_comb begin
    mode0_req = OP_NONE;
    mode1_req = OP_NONE;
    data_op   = OP_NONE;
    if (bus_we) begin
      if (bus_addr == ADDR_W'(OFS_MODE1)) mode1_req = OP_LOAD;
      if (bus_addr == ADDR_W'(OFS_M1CLR)) mode1_req = OP_CLR;
      if (bus_addr == ADDR_W'(OFS_MODE0)) mode0_req = OP_LOAD;
      if (bus_addr == ADDR_W'(OFS_M0SET)) mode0_req = OP_SET;
      if (bus_addr == ADDR_W'(OFS_M0CLR)) mode0_req = OP_CLR;
      if (bus_addr == ADDR_W'(OFS_DSET))  data_op   = OP_SET;
      if (bus_addr == ADDR_W'(OFS_DCLR))  data_op   = OP_CLR;
    end
  end

  // Mode writes pass only under a lock opened on an earlier edge
  assign mode0_op = lock_active ? mode0_req : OP_NONE;
  assign mode1_op = lock_active ? mode1_req : OP_NONE;

  gpio_kp_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (lock_we),
    .key    (lock_wdata[KEY_W-1:0]),
    .active (lock_active)
  );

  gpio_kp_bitreg #(.W(NPINS)) u_mode0 (
    .clk (clk), .rst_n (rst_n), .op (mode0_op), .wd (wd_pins), .q (mode0_q)
  );

  gpio_kp_bitreg #(.W(NPINS)) u_mode1 (
    .clk (clk), .rst_n (rst_n), .op (mode1_op), .wd (wd_pins), .q (mode1_q)
  );

  gpio_kp_bitreg #(.W(NPINS)) u_data (
    .clk (clk), .rst_n (rst_n), .op (data_op), .wd (wd_pins), .q (data_q)
  );

  gpio_kp_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk), .rst_n (rst_n), .d (pad_in), .q (din_q)
  );

  gpio_kp_pad #(.W(NPINS)) u_pad (
    .mode1 (mode1_q),
    .mode0 (mode0_q),
    .data  (data_q),
    .oe    (pad_oe),
    .out   (pad_out)
  );

  // Read mux, upper bits zero-extended
  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_DIN))   bus_rdata = 32'(din_q);
    if (bus_addr == ADDR_W'(OFS_MODE1)) bus_rdata = 32'(mode1_q);
    if (bus_addr == ADDR_W'(OFS_MODE0)) bus_rdata = 32'(mode0_q);
  end

  assign lock_rdata = {lock_active, 31'b0};

endmodule

// File: rtl/gpio_keyed_pads_chk.sv
module gpio_keyed_pads_chk
  import gpio_kp_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lock_we,
  input logic [31:0]       lock_wdata,
  input logic              lock_active,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [NPINS-1:0]  mode0_q,
  input logic [NPINS-1:0]  mode1_q,
  input logic [NPINS-1:0]  data_q,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  pad_out
);

  a_r2_key_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_we && lock_wdata[15:0] == 16'hD42F) |=> lock_active);

  a_r2_other_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_we && lock_wdata[15:0] != 16'hD42F) |=> !lock_active);

  a_r2_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_we |=> $stable(lock_active));

  a_r3_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !lock_active |=> ($stable(mode0_q) && $stable(mode1_q)));

  a_r6_data_set: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_DSET)) |=>
      ((data_q & $past(bus_wdata[NPINS-1:0])) == $past(bus_wdata[NPINS-1:0])));

  a_r6_data_clr: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == ADDR_W'(OFS_DCLR)) |=>
      ((data_q & $past(bus_wdata[NPINS-1:0])) == '0));

  a_r7_input_floats: assert property (@(posedge clk) disable iff (!rst_n)
    ((~mode0_q & ~mode1_q & pad_oe) == '0));

  a_r7_out_low_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_out & ~pad_oe) == '0));

endmodule

bind gpio_keyed_pads gpio_keyed_pads_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .lock_we     (lock_we),
  .lock_wdata  (lock_wdata),
  .lock_active (lock_active),
  .bus_we      (bus_we),
  .bus_addr    (bus_addr),
  .bus_wdata   (bus_wdata),
  .mode0_q     (mode0_q),
  .mode1_q     (mode1_q),
  .data_q      (data_q),
  .pad_oe      (pad_oe),
  .pad_out     (pad_out)
);

// File: tb/sim_gpio_keyed_pads.sv
module sim_gpio_keyed_pads;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 24;
  localparam logic [31:0] PM = 32'h00FF_FFFF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        lock_we = 1'b0;
  logic [31:0] lock_wdata = '0;
  logic [31:0] lock_rdata;
  logic [NP-1:0] pad_in = '0;
  logic [NP-1:0] pad_out, pad_oe;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_keyed_pads #(.NPINS(NP), .ADDR_W(8)) u0 (
    .clk, .rst_n, .bus_addr, .bus_we, .bus_wdata, .bus_rdata,
    .lock_we, .lock_wdata, .lock_rdata, .pad_in, .pad_out, .pad_oe
  );

  // {mode1, mode0, data, expected oe, expected out}
  localparam logic [4:0] PAD_TBL [8] = '{
    5'b00000, 5'b00100, 5'b01010, 5'b01111,
    5'b10010, 5'b10100, 5'b11000, 5'b11111
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic lk(input logic [31:0] d);
    @(negedge clk); lock_wdata = d; lock_we = 1'b1;
    @(negedge clk); lock_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 lock", lock_rdata, 32'h0);
    chk("R1 oe", 32'(pad_oe), 32'h0);
    chk("R1 out", 32'(pad_out), 32'h0);
    rd(8'h0C, v); chk("R1 mode0", v, 32'h0);
    rd(8'h08, v); chk("R1 mode1", v, 32'h0);

    // R3 locked writes ignored
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h54, 32'h0000_00FF);
    rd(8'h0C, v); chk("R3 mode0 while locked", v, 32'h0);

    // R3 same-cycle key and mode write: mode write dropped
    @(negedge clk);
    lock_wdata = 32'h0000_D42F; lock_we = 1'b1;
    bus_addr = 8'h0C; bus_wdata = 32'h0000_1234; bus_we = 1'b1;
    @(negedge clk); lock_we = 1'b0; bus_we = 1'b0;
    rd(8'h0C, v); chk("R3 same-cycle dropped", v, 32'h0);
    chk("R2 open", lock_rdata, 32'h8000_0000);

    // R4 / R9 full load and readback, upper bits zero
    wr(8'h0C, 32'hA5A5_A5A5);
    rd(8'h0C, v); chk("R4 R9 mode0 load", v, 32'hA5A5_A5A5 & PM);
    wr(8'h08, 32'h5A5A_5A5A);
    rd(8'h08, v); chk("R4 R9 mode1 load", v, 32'h5A5A_5A5A & PM);

    // R5 bitwise set/clear
    wr(8'h54, 32'h0000_000F);
    rd(8'h0C, v); chk("R5 mode0 set", v, 32'h00A5_A5AF);
    wr(8'h58, 32'h0000_A500);
    rd(8'h0C, v); chk("R5 mode0 clr", v, 32'h00A5_00AF);
    wr(8'h50, 32'h005A_0000);
    rd(8'h08, v); chk("R5 mode1 clr", v, 32'h0000_5A5A);

    // R2 wrong key closes, then mode writes ignored (R3)
    lk(32'hFFFF_1234);
    chk("R2 wrong key closes", lock_rdata, 32'h0);
    wr(8'h08, 32'h0);
    rd(8'h08, v); chk("R3 mode1 after close", v, 32'h0000_5A5A);
    lk(32'h0000_D42F);
    lk(32'h0000_0000);
    chk("R2 zero releases", lock_rdata, 32'h0);

    // R7 drive table
    for (int i = 0; i < 8; i++) begin
      logic [4:0] e;
      e = PAD_TBL[i];
      lk(32'h0000_D42F);
      wr(8'h08, e[4] ? 32'hFFFF_FFFF : 32'h0);
      wr(8'h0C, e[3] ? 32'hFFFF_FFFF : 32'h0);
      wr(e[2] ? 8'h14 : 8'h18, 32'hFFFF_FFFF);
      lk(32'h0);
      chk($sformatf("R7 oe case %0d", i), 32'(pad_oe), e[1] ? PM : 32'h0);
      chk($sformatf("R7 out case %0d", i), 32'(pad_out), e[0] ? PM : 32'h0);
    end

    // R6 data set/clear under push-pull, lock closed
    lk(32'h0000_D42F);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    lk(32'h0);
    wr(8'h18, 32'hFFFF_FFFF);
    wr(8'h14, 32'h0000_0F0F);
    chk("R6 data set", 32'(pad_out), 32'h0000_0F0F);
    wr(8'h14, 32'h00F0_0000);
    chk("R6 set keeps others", 32'(pad_out), 32'h00F0_0F0F);
    wr(8'h18, 32'h0000_0F00);
    chk("R6 data clr", 32'(pad_out), 32'h00F0_000F);

    // R10 unmapped offsets
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, v); chk("R10 unmapped read", v, 32'h0);
    chk("R10 unmapped write", 32'(pad_out), 32'h00F0_000F);

    // R8 input synchronizer: two edges
    @(negedge clk); pad_in = 24'hC3_5A96;
    rd(8'h04, v); chk("R8 no edge yet", v, 32'h0);
    @(negedge clk);
    rd(8'h04, v); chk("R8 one edge", v, 32'h0);
    @(negedge clk);
    rd(8'h04, v); chk("R8 two edges", v, 32'h00C3_5A96);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule